// File: doc/BRIEF.md
# Constant-Resolution Digital Zoom Subsampler

This block sits in a streaming sensor path and turns a 2048x2048 pixel stream into a 512x512 stream at every zoom level, so the downstream link always carries the same number of pixels per frame. The zoom level sets two things together: a window centred on the sensor and a sampling step inside that window. At 1x the window is the whole frame and one pixel in four is kept along each axis. At 2x the window is the central 1024x1024 region and one pixel in two is kept. At 4x the window is the central 512x512 region and every pixel in it is kept.

The input is a pixel stream qualified by a valid strobe, with a start-of-frame marker on the first pixel of a frame and a start-of-line marker on the first pixel of each line. The zoom select is sampled together with the start-of-frame pixel and holds for the whole frame. The output is a registered pixel stream with its own start-of-frame and start-of-line markers. Sensor and output sizes are parameters. The window for each zoom level scales with them, centred, and the 1x step is the ratio of input width to output width.

Top module: `zoom_subsampler`

## Requirements
- R1: With zoom code 00 (1x), the pixels kept are those whose row and column are both multiples of 4 (0, 4, ..., 2044), giving 512 kept pixels in each of 512 kept rows.
- R2: With zoom code 01 (2x), the pixels kept are those with row and column in 512..1535 whose offset from 512 is a multiple of 2.
- R3: With zoom code 10 (4x), every pixel with row and column in 768..1279 is kept and no other pixel is.
- R4: Zoom code 11 gives exactly the same selection as code 00.
- R5: Every complete input frame yields exactly 512x512 output pixels, 512 in each output line, at every zoom level.
- R6: out_sol is high on the first kept pixel of each kept row and on no other output. out_sof is high only on the first kept pixel of the frame, and it is always accompanied by out_sol.
- R7: zoom_sel is sampled only on the input pixel that carries in_sof. A change of zoom_sel within a frame does not alter that frame's selection.
- R8: A kept pixel appears on out_data with out_valid high exactly one clock after it is accepted, with its value unchanged. Cycles with in_valid low do not advance the position and produce no output.
- R9: While rst is high and in the first cycle after it, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pixel qualifier |
| in_sof | input | 1 | High on the first pixel of an input frame |
| in_sol | input | 1 | High on the first pixel of each input line |
| in_data | input | PIX_W | Input pixel value |
| zoom_sel | input | 2 | Zoom code: 00 1x, 01 2x, 10 4x, 11 as 1x |
| out_valid | output | 1 | Output pixel qualifier |
| out_sof | output | 1 | High on the first output pixel of a frame |
| out_sol | output | 1 | High on the first output pixel of each output line |
| out_data | output | PIX_W | Output pixel value |

## Verification
The bench runs at a reduced size (a 64x64 sensor into a 16x16 output), which keeps the same window and step proportions. It sends one full frame at each of the four zoom codes. Each pixel carries a value unique to its row, column and frame, so a wrong window origin, a wrong step or a wrong phase shows up as a mismatched value at its position in the output order. A frame whose zoom select changes halfway through separates sampling at frame start from sampling on every pixel. A frame with idle gaps between pixels shows whether positions advance only on accepted pixels.

// File: rtl/zrs_pkg.sv
package zrs_pkg;

  typedef enum logic [1:0] {
    ZOOM_X1  = 2'b00,
    ZOOM_X2  = 2'b01,
    ZOOM_X4  = 2'b10,
    ZOOM_RSV = 2'b11
  } zoom_e;

  // Number of halvings of the base step for a zoom code.
  function automatic logic [1:0] zoom_to_shift(input logic [1:0] code);
    case (zoom_e'(code))
      ZOOM_X2: zoom_to_shift = 2'd1;
      ZOOM_X4: zoom_to_shift = 2'd2;
      default: zoom_to_shift = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/zrs_zoom_latch.sv
module zrs_zoom_latch
  import zrs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_start,
  input  logic [1:0] zoom_sel,
  output logic [1:0] cur_shift
);

  logic [1:0] shift_q;

  // The start pixel itself already uses the new code.
  always_comb begin
    if (frame_start) cur_shift = zoom_to_shift(zoom_sel);
    else             cur_shift = shift_q;
  end

  always_ff @(posedge clk) begin
    if (rst)              shift_q <= 2'd0;
    else if (frame_start) shift_q <= zoom_to_shift(zoom_sel);
  end

endmodule

// File: rtl/zrs_pos_track.sv
module zrs_pos_track #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          px_valid,
  input  logic          px_sof,
  input  logic          px_sol,
  output logic [CW-1:0] col_now,
  output logic [CW-1:0] row_now
);

  logic [CW-1:0] col_q;
  logic [CW-1:0] row_q;

  always_comb begin
    if (px_sof) begin
      col_now = '0;
      row_now = '0;
    end else if (px_sol) begin
      col_now = '0;
      row_now = row_q + CW'(1);
    end else begin
      col_now = col_q + CW'(1);
      row_now = row_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q <= '0;
      row_q <= '0;
    end else if (px_valid) begin
      col_q <= col_now;
      row_q <= row_now;
    end
  end

endmodule

// File: rtl/zrs_axis_window.sv
module zrs_axis_window #(
  parameter int IN_N     = 2048,
  parameter int OUT_N    = 512,
  parameter int STEP1_LG = 2,
  parameter int CW       = 12
) (
  input  logic [CW-1:0] pos,
  input  logic [1:0]    shift,
  output logic          keep,
  output logic          first
);

  localparam int XW = CW + 2;

  logic [4:0]    step_lg;
  logic [XW-1:0] p;
  logic [XW-1:0] win;
  logic [XW-1:0] org;
  logic [XW-1:0] off;
  logic [XW-1:0] mask;

  always_comb begin
    step_lg = 5'(STEP1_LG) - {3'b000, shift};
    p       = XW'(pos);
    win     = XW'(OUT_N) << step_lg;
    org     = (XW'(IN_N) - win) >> 1;
    mask    = (XW'(1) << step_lg) - XW'(1);
    off     = p - org;
    keep    = (p >= org) && (p < (org + win)) && ((off & mask) == '0);
    first   = (p == org);
  end

endmodule

// File: rtl/zrs_out_stage.sv
module zrs_out_stage #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             is_frame_first,
  input  logic             is_line_first,
  input  logic [PIX_W-1:0] px_data,
  output logic             out_valid,
  output logic             out_sof,
  output logic             out_sol,
  output logic [PIX_W-1:0] out_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_sol   <= 1'b0;
    end else begin
      out_valid <= take;
      out_sof   <= take && is_frame_first;
      out_sol   <= take && is_line_first;
    end
  end

  always_ff @(posedge clk) begin
    if (take) out_data <= px_data;
  end

endmodule

// File: rtl/zoom_subsampler.sv
module zoom_subsampler #(
  parameter int IN_W  = 2048,
  parameter int IN_H  = 2048,
  parameter int OUT_W = 512,
  parameter int OUT_H = 512,
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_sol,
  input  logic [PIX_W-1:0] in_data,
  input  logic [1:0]       zoom_sel,
  output logic             out_valid,
  output logic             out_sof,
  output logic             out_sol,
  output logic [PIX_W-1:0] out_data
);

  localparam int STEP1_LG = $clog2(IN_W / OUT_W);
  localparam int MAX_N    = (IN_W > IN_H) ? IN_W : IN_H;
  localparam int CW       = $clog2(MAX_N + 1);

  logic [1:0]    cur_shift;
  logic [CW-1:0] col_now;
  logic [CW-1:0] row_now;
  logic [1:0]    ax_keep;
  logic [1:0]    ax_first;
  logic [CW-1:0] ax_pos [2];

  zrs_zoom_latch u_zoom (
    .clk         (clk),
    .rst         (rst),
    .frame_start (in_valid && in_sof),
    .zoom_sel    (zoom_sel),
    .cur_shift   (cur_shift)
  );

  zrs_pos_track #(.CW(CW)) u_pos (
    .clk      (clk),
    .rst      (rst),
    .px_valid (in_valid),
    .px_sof   (in_sof),
    .px_sol   (in_sol),
    .col_now  (col_now),
    .row_now  (row_now)
  );

  assign ax_pos[0] = col_now;
  assign ax_pos[1] = row_now;

  // Axis 0 is horizontal, axis 1 vertical.
  for (genvar a = 0; a < 2; a++) begin : g_axis
    localparam int N_IN  = (a == 0) ? IN_W  : IN_H;
    localparam int N_OUT = (a == 0) ? OUT_W : OUT_H;
    zrs_axis_window #(
      .IN_N     (N_IN),
      .OUT_N    (N_OUT),
      .STEP1_LG (STEP1_LG),
      .CW       (CW)
    ) u_win (
      .pos   (ax_pos[a]),
      .shift (cur_shift),
      .keep  (ax_keep[a]),
      .first (ax_first[a])
    );
  end

  zrs_out_stage #(.PIX_W(PIX_W)) u_out (
    .clk            (clk),
    .rst            (rst),
    .take           (in_valid && (&ax_keep)),
    .is_frame_first (&ax_first),
    .is_line_first  (ax_first[0]),
    .px_data        (in_data),
    .out_valid      (out_valid),
    .out_sof        (out_sof),
    .out_sol        (out_sol),
    .out_data       (out_data)
  );

endmodule

// File: rtl/zrs_checker.sv
module zrs_checker #(
  parameter int OUT_W = 512,
  parameter int OUT_H = 512,
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [PIX_W-1:0] in_data,
  input logic             out_valid,
  input logic             out_sof,
  input logic             out_sol,
  input logic [PIX_W-1:0] out_data
);

  localparam int FW = $clog2(OUT_W * OUT_H + 2);
  localparam int LW = $clog2(OUT_W + 2);

  logic [FW-1:0] frame_cnt;
  logic [LW-1:0] line_cnt;
  logic          frame_seen;
  logic          line_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_cnt  <= '0;
      line_cnt   <= '0;
      frame_seen <= 1'b0;
      line_seen  <= 1'b0;
    end else if (out_valid) begin
      frame_cnt <= out_sof ? FW'(1) : frame_cnt + FW'(1);
      line_cnt  <= out_sol ? LW'(1) : line_cnt + LW'(1);
      if (out_sof) frame_seen <= 1'b1;
      if (out_sol) line_seen  <= 1'b1;
    end
  end

  // R5
  frame_size_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sof && frame_seen) |-> (frame_cnt == FW'(OUT_W * OUT_H)));

  // R5
  line_size_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sol && line_seen) |-> (line_cnt == LW'(OUT_W)));

  // R6
  sof_with_sol_chk: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> (out_sol && out_valid));

  // R6
  sol_qualified_chk: assert property (@(posedge clk) disable iff (rst)
    out_sol |-> out_valid);

  // R8
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(in_valid) && (out_data == $past(in_data))));

endmodule

bind zoom_subsampler zrs_checker #(
  .OUT_W (OUT_W),
  .OUT_H (OUT_H),
  .PIX_W (PIX_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_sof   (out_sof),
  .out_sol   (out_sol),
  .out_data  (out_data)
);

// File: tb/zoom_subsampler_tb_top.sv
module zoom_subsampler_tb_top;

  localparam int IW = 64;
  localparam int IH = 64;
  localparam int OW = 16;
  localparam int OH = 16;
  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          in_sof = 1'b0;
  logic          in_sol = 1'b0;
  logic [PW-1:0] in_data = '0;
  logic [1:0]    zoom_sel = 2'b00;
  logic          out_valid;
  logic          out_sof;
  logic          out_sol;
  logic [PW-1:0] out_data;

  int n_checks = 0;
  int n_fail   = 0;
  int got_pix  = 0;
  int got_sol  = 0;
  string cur_tag = "R1";
  logic [PW+1:0] exp_q[$];

  always #10 clk = ~clk;

  zoom_subsampler #(
    .IN_W (IW), .IN_H (IH), .OUT_W (OW), .OUT_H (OH), .PIX_W (PW)
  ) dut_i (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_sof (in_sof),
    .in_sol (in_sol), .in_data (in_data), .zoom_sel (zoom_sel),
    .out_valid (out_valid), .out_sof (out_sof), .out_sol (out_sol),
    .out_data (out_data)
  );

  task automatic check(input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Monitor: pops one expected item per output pixel.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      got_pix++;
      if (out_sol) got_sol++;
      if (exp_q.size() == 0) begin
        check(cur_tag, "unexpected output pixel", 1, 0);
      end else begin
        logic [PW+1:0] e;
        e = exp_q.pop_front();
        check(cur_tag, "pixel {sof,sol,data}",
              int'({out_sof, out_sol, out_data}), int'(e));
      end
    end
  end

  function automatic logic [PW-1:0] pix_val(input int r, input int c, input int f);
    return PW'(r * 7 + c * 3 + f * 11);
  endfunction

  // Drives one full frame. zoom_at_sof is the code sampled at frame start;
  // mid_code is applied from the middle row on; gaps inserts idle cycles.
  task automatic send_frame(input string tag, input int f,
                            input logic [1:0] zoom_at_sof,
                            input logic [1:0] mid_code, input bit gaps);
    int step, org, win;
    cur_tag = tag;
    got_pix = 0;
    got_sol = 0;
    step = (zoom_at_sof == 2'b01) ? 2 : (zoom_at_sof == 2'b10) ? 1 : 4;
    win  = OW * step;
    org  = (IW - win) / 2;
    for (int r = 0; r < IH; r++) begin
      for (int c = 0; c < IW; c++) begin
        if (gaps && ((r + c) % 7 == 3)) begin
          @(negedge clk);
          in_valid = 1'b0;
          in_sof   = 1'b0;
          in_sol   = 1'b0;
          in_data  = 8'hA5;
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_sof   = (r == 0) && (c == 0);
        in_sol   = (c == 0);
        in_data  = pix_val(r, c, f);
        zoom_sel = (r >= IH / 2) ? mid_code : zoom_at_sof;
        if (r >= org && r < org + win && (r - org) % step == 0 &&
            c >= org && c < org + win && (c - org) % step == 0)
          exp_q.push_back({(r == org) && (c == org), (c == org), pix_val(r, c, f)});
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_sol   = 1'b0;
    repeat (3) @(negedge clk);
    check(tag, "missing output pixels", exp_q.size(), 0);
    check("R5", "pixels per frame", got_pix, OW * OH);
    check("R6", "line starts per frame", got_sol, OH);
    exp_q.delete();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    // R9: outputs idle during reset
    check("R9", "out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R9", "out_valid after reset", int'(out_valid), 0);

    send_frame("R1", 1, 2'b00, 2'b00, 1'b0);
    send_frame("R2", 2, 2'b01, 2'b01, 1'b0);
    send_frame("R3", 3, 2'b10, 2'b10, 1'b0);
    send_frame("R4", 4, 2'b11, 2'b11, 1'b0);
    // R7: zoom changes halfway through; frame-start code must hold
    send_frame("R7", 5, 2'b01, 2'b10, 1'b0);
    // R8: idle gaps between pixels
    send_frame("R8", 6, 2'b10, 2'b10, 1'b1);

    // R8: idle input gives no output
    repeat (4) @(negedge clk);
    check("R8", "out_valid while idle", int'(out_valid), 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule